// File: doc/BRIEF.md
# RMII Ethernet Frame Transmitter

This block produces complete Ethernet frames on a 2-bit RMII transmit path. Every register runs on the single RMII reference clock, which times both directions of the PHY link. A free-running 8-bit counter stands in for payload traffic: its value is offered to an internal byte FIFO on every clock. Once the FIFO holds more bytes than the configured payload length, a frame starts.

Each frame is sent as dibits, one per clock with TXEN high, in a fixed field order: preamble, start-of-frame delimiter, a fixed 14-byte header chosen by parameters, the payload (padded with zero bytes to the Ethernet minimum), and a CRC-32 frame check sequence. After the last FCS dibit the block holds TXEN low for an inter-frame gap. It then returns to idle and waits for the next start condition. The reset input `rst_n` is asynchronous on assertion and must be released in step with `clk`.

Top module: `rmii_frame_tx`

## Requirements
- R1: While `rst_n` is low, `txen` is 0 and `txd` is 0.
- R2: The payload counter is 0 on the first clock edge after reset and increments by one (mod 256) on every edge. On each edge it is written into a FIFO of FIFO_DEPTH bytes unless the FIFO was already full before that edge; a read in the same edge does not free room for the write. Payload bytes leave the FIFO in write order.
- R3: In idle, an edge at which the FIFO holds more than PAYLOAD_LEN bytes starts a frame, and `txen` is 1 right after that edge.
- R4: A frame opens with seven 0x55 bytes, then one 0xD5 byte. Every byte of the frame goes out on `txd` least-significant dibit first, one dibit per clock.
- R5: After the delimiter come 14 header bytes formed from {DST_ADDR, SRC_ADDR, ETH_TYPE}, most significant byte first.
- R6: Next come PAYLOAD_LEN bytes read from the FIFO. If PAYLOAD_LEN is below 46, zero bytes follow until 46 payload bytes have been sent.
- R7: The last four bytes are the complement of a reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones). The CRC is taken over header, payload and pad, and is sent low byte first.
- R8: `txen` stays 1 from the first preamble dibit to the last FCS dibit, and `txd` is 0 whenever `txen` is 0.
- R9: After the last FCS dibit, `txen` stays 0 for GAP_CLKS clocks (48 by default). One idle clock follows before a new frame can begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RMII reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| txen | output | 1 | Transmit enable to the PHY |
| txd | output | 2 | Transmit dibit to the PHY |

## Verification
The bench drives two instances, one with a payload shorter than the Ethernet minimum and one longer. The short one exercises zero padding, so a design that padded with FIFO data or sent a short frame corrupts the FCS and the frame length. The long one exercises the full payload read, where an off-by-one in the last payload byte read would show. After the first frame the FIFO stays full, so the dropped-write rule is hit. A FIFO that let a same-edge read free room for a write would shift every later payload value. The start threshold, the inclusion of the last payload dibit in the CRC, and the exact gap length each move `txen` or `txd` by at least one clock against the reference, which compares both outputs on every cycle.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_SFD  = 3'd2,
    ST_HDR  = 3'd3,
    ST_DATA = 3'd4,
    ST_FCS  = 3'd5,
    ST_WAIT = 3'd6
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;

  // Advance a reflected CRC-32 by two bits, bit 0 first.
  function automatic logic [31:0] crc_dibit_step(input logic [31:0] c, input logic [1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 2; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic tx_state_e state_succ(input tx_state_e s);
    case (s)
      ST_IDLE: return ST_PRE;
      ST_PRE:  return ST_SFD;
      ST_SFD:  return ST_HDR;
      ST_HDR:  return ST_DATA;
      ST_DATA: return ST_FCS;
      ST_FCS:  return ST_WAIT;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q, count_d;
  logic             push;

  // Fullness is judged before the edge; a same-edge read does not make room.
  assign push = wr_req && (count_q != FULL_LVL);

  always_comb begin
    count_d = count_q;
    if (push && !rd_en)      count_d = count_q + 1'b1;
    else if (!push && rd_en) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push)  wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en) rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_d;
    end
  end

  assign rd_data = mem[rd_ptr_q];
  assign count   = count_q;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_LVL);

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count_q != '0));

endmodule

// File: rtl/crc32_dibit.sv
module crc32_dibit
  import rmii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [1:0]  din,
  output logic [31:0] crc_nxt
);

  logic [31:0] crc_q;

  always_comb begin
    if (clr)     crc_nxt = '1;
    else if (en) crc_nxt = crc_dibit_step(crc_q, din);
    else         crc_nxt = crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_nxt;
  end

  p_crc_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import rmii_tx_pkg::*;
#(
  parameter int           PAYLOAD_LEN = 40,
  parameter int           MIN_PAYLOAD = 46,
  parameter int           GAP_CLKS    = 48,
  parameter int           FIFO_CW     = 7,
  parameter logic [111:0] HEADER      = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIFO_CW-1:0] fifo_count,
  input  logic [7:0]         fifo_head,
  input  logic [31:0]        crc_nxt,
  output logic               fifo_pop,
  output logic               crc_en,
  output logic               crc_clr,
  output logic               txen,
  output logic [1:0]         txd
);

  localparam int HDR_BYTES = 14;
  localparam int PRE_BYTES = 7;
  localparam int PAY_BYTES = (PAYLOAD_LEN < MIN_PAYLOAD) ? MIN_PAYLOAD : PAYLOAD_LEN;
  localparam int MAXF      = (PAY_BYTES > HDR_BYTES) ? PAY_BYTES : HDR_BYTES;
  localparam int BW        = $clog2(MAXF + 1);
  localparam int GW        = $clog2(GAP_CLKS + 1);

  localparam logic [BW-1:0]      PRE_LAST  = BW'(PRE_BYTES - 1);
  localparam logic [BW-1:0]      HDR_LAST  = BW'(HDR_BYTES - 1);
  localparam logic [BW-1:0]      PAY_LAST  = BW'(PAY_BYTES - 1);
  localparam logic [BW-1:0]      REAL_LAST = BW'(PAYLOAD_LEN - 1);
  localparam logic [BW-1:0]      FCS_LAST  = BW'(3);
  localparam logic [GW-1:0]      GAP_LAST  = GW'(GAP_CLKS - 1);
  localparam logic [FIFO_CW-1:0] START_LVL = FIFO_CW'(PAYLOAD_LEN);

  tx_state_e     state_q, state_d;
  logic [1:0]    dib_q, dib_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [7:0]    byte_q, byte_d;
  logic [31:0]   fcs_q, fcs_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          byte_end;
  logic          fifo_ready;

  function automatic logic [7:0] hdr_byte(input logic [BW-1:0] idx);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (idx == BW'(i)) r = HEADER[8*(HDR_BYTES-1-i) +: 8];
    end
    return r;
  endfunction

  assign byte_end   = (dib_q == 2'd3);
  assign fifo_ready = (fifo_count > START_LVL);

  always_comb begin
    state_d  = state_q;
    dib_d    = dib_q + 1'b1;
    bcnt_d   = bcnt_q;
    byte_d   = byte_q >> 2;
    fcs_d    = fcs_q;
    gap_d    = gap_q;
    fifo_pop = 1'b0;
    case (state_q)
      ST_IDLE: begin
        dib_d  = '0;
        bcnt_d = '0;
        gap_d  = '0;
        byte_d = byte_q;
        if (fifo_ready) begin
          state_d = ST_PRE;
          byte_d  = PRE_BYTE;
        end
      end
      ST_PRE: begin
        if (byte_end) begin
          if (bcnt_q == PRE_LAST) begin
            state_d = ST_SFD;
            bcnt_d  = '0;
            byte_d  = SFD_BYTE;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            byte_d = PRE_BYTE;
          end
        end
      end
      ST_SFD: begin
        if (byte_end) begin
          state_d = ST_HDR;
          bcnt_d  = '0;
          byte_d  = hdr_byte('0);
        end
      end
      ST_HDR: begin
        if (byte_end) begin
          if (bcnt_q == HDR_LAST) begin
            state_d  = ST_DATA;
            bcnt_d   = '0;
            byte_d   = fifo_head;
            fifo_pop = 1'b1;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            byte_d = hdr_byte(bcnt_q + 1'b1);
          end
        end
      end
      ST_DATA: begin
        if (byte_end) begin
          if (bcnt_q == PAY_LAST) begin
            state_d = ST_FCS;
            bcnt_d  = '0;
            fcs_d   = ~crc_nxt;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            if (bcnt_q < REAL_LAST) begin
              byte_d   = fifo_head;
              fifo_pop = 1'b1;
            end else begin
              byte_d = '0;
            end
          end
        end
      end
      ST_FCS: begin
        fcs_d = fcs_q >> 2;
        if (byte_end) begin
          if (bcnt_q == FCS_LAST) begin
            state_d = ST_WAIT;
            gap_d   = '0;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        dib_d  = '0;
        byte_d = byte_q;
        if (gap_q == GAP_LAST) state_d = ST_IDLE;
        else                   gap_d   = gap_q + 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        dib_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dib_q   <= '0;
      bcnt_q  <= '0;
      byte_q  <= '0;
      fcs_q   <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      dib_q   <= dib_d;
      bcnt_q  <= bcnt_d;
      byte_q  <= byte_d;
      fcs_q   <= fcs_d;
      gap_q   <= gap_d;
    end
  end

  always_comb begin
    txen = (state_q != ST_IDLE) && (state_q != ST_WAIT);
    if (state_q == ST_FCS) txd = fcs_q[1:0];
    else if (txen)         txd = byte_q[1:0];
    else                   txd = 2'b00;
    crc_en  = (state_q == ST_HDR) || (state_q == ST_DATA);
    crc_clr = (state_q == ST_IDLE);
  end

  p_state_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> (state_q == state_succ($past(state_q))));

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0));

  p_txen_ends_in_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen) |-> (state_q == ST_WAIT));

  p_start_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> ($past(fifo_count) > START_LVL));

endmodule

// File: rtl/rmii_frame_tx.sv
module rmii_frame_tx #(
  parameter int          PAYLOAD_LEN = 40,
  parameter int          FIFO_DEPTH  = 64,
  parameter int          GAP_CLKS    = 48,
  parameter logic [47:0] DST_ADDR    = 48'h0A1B_2C3D_4E5F,
  parameter logic [47:0] SRC_ADDR    = 48'h0260_8C12_3456,
  parameter logic [15:0] ETH_TYPE    = 16'h88B5
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       txen,
  output logic [1:0] txd
);

  localparam int FIFO_CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [111:0] HEADER = {DST_ADDR, SRC_ADDR, ETH_TYPE};

  logic [7:0]         tmr_q;
  logic               tmr_en;
  logic [7:0]         fifo_head;
  logic [FIFO_CW-1:0] fifo_count;
  logic               fifo_pop;
  logic               crc_en, crc_clr;
  logic [31:0]        crc_nxt;
  logic               txen_w;
  logic [1:0]         txd_w;

  assign tmr_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_q + 1'b1;
  end

  byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (tmr_en),
    .wr_data (tmr_q),
    .rd_en   (fifo_pop),
    .rd_data (fifo_head),
    .count   (fifo_count)
  );

  crc32_dibit crc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (crc_clr),
    .en      (crc_en),
    .din     (txd_w),
    .crc_nxt (crc_nxt)
  );

  frame_ctrl #(
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .MIN_PAYLOAD (46),
    .GAP_CLKS    (GAP_CLKS),
    .FIFO_CW     (FIFO_CW),
    .HEADER      (HEADER)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .fifo_head  (fifo_head),
    .crc_nxt    (crc_nxt),
    .fifo_pop   (fifo_pop),
    .crc_en     (crc_en),
    .crc_clr    (crc_clr),
    .txen       (txen_w),
    .txd        (txd_w)
  );

  assign txen = txen_w;
  assign txd  = txd_w;

endmodule

// File: tb/rmii_frame_tx_tb_top.sv
`timescale 1ns/1ps

module frame_ref_model #(
  parameter int           L     = 40,
  parameter int           DEPTH = 64,
  parameter int           GAP   = 48,
  parameter logic [111:0] HDR   = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txen,
  input  logic [1:0] txd,
  output int         n_chk,
  output int         n_err,
  output int         n_frames
);

  localparam int PAY = (L < 46) ? 46 : L;
  localparam int NB  = 8 + 14 + PAY + 4;
  localparam int NS  = NB * 4;

  logic [7:0] q[$];
  logic [7:0] fb[NB];
  int tmr, mode, slot, gcnt;

  task automatic fill_fcs();
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 8; i < 22 + PAY; i++) begin
      c = c ^ {24'h0, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fb[22 + PAY + k] = c[8*k +: 8];
  endtask

  task automatic advance();
    int pre;
    int b;
    pre = q.size();
    if (mode == 0) begin
      if (pre > L) begin
        mode = 1;
        slot = 0;
        n_frames++;
        for (int i = 0; i < NB; i++) fb[i] = 8'h00;
        for (int i = 0; i < 7; i++) fb[i] = 8'h55;
        fb[7] = 8'hD5;
        for (int i = 0; i < 14; i++) fb[8 + i] = HDR[8*(13-i) +: 8];
      end
    end else if (mode == 1) begin
      slot++;
      if (slot == NS) begin
        mode = 2;
        gcnt = 0;
      end else if (slot % 4 == 0) begin
        b = slot / 4;
        if (b >= 22 && b < 22 + L) fb[b] = q.pop_front();
        if (b == 22 + PAY) fill_fcs();
      end
    end else begin
      if (gcnt == GAP - 1) mode = 0;
      else gcnt++;
    end
    if (pre < DEPTH) q.push_back(tmr[7:0]);
    tmr = (tmr + 1) % 256;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      tmr = 0; mode = 0; slot = 0; gcnt = 0;
      n_chk = 0; n_err = 0; n_frames = 0;
    end else begin
      logic       e_en;
      logic [1:0] e_d;
      string      tag;
      int         b;
      advance();
      e_en = (mode == 1);
      e_d  = 2'b00;
      tag  = (mode == 0) ? "R3 idle/start" : "R9 gap";
      if (mode == 1) begin
        b   = slot / 4;
        e_d = fb[b][2*(slot%4) +: 2];
        if (b < 8)            tag = "R4 preamble/SFD, R8";
        else if (b < 22)      tag = "R5 header, R8";
        else if (b < 22 + PAY) tag = "R6 payload, R2 content, R8";
        else                  tag = "R7 FCS, R8";
      end
      n_chk++;
      if (txen !== e_en || txd !== e_d) begin
        n_err++;
        $display("FAIL %s (L=%0d slot %0d): txen=%b txd=%b expected txen=%b txd=%b",
                 tag, L, slot, txen, txd, e_en, e_d);
      end
    end
  end

endmodule

module rmii_frame_tx_tb_top;

  localparam logic [47:0] DST  = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] SRC  = 48'h0260_8C12_3456;
  localparam logic [15:0] ETYP = 16'h88B5;
  localparam logic [111:0] HDR = {DST, SRC, ETYP};

  logic clk, rst_n;
  logic txen_a, txen_b;
  logic [1:0] txd_a, txd_b;
  int chk_a, err_a, frm_a, chk_b, err_b, frm_b;
  int checks, errors;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  rmii_frame_tx #(.PAYLOAD_LEN(40), .FIFO_DEPTH(64), .GAP_CLKS(48),
                  .DST_ADDR(DST), .SRC_ADDR(SRC), .ETH_TYPE(ETYP)) dut_i (
    .clk(clk), .rst_n(rst_n), .txen(txen_a), .txd(txd_a));

  rmii_frame_tx #(.PAYLOAD_LEN(50), .FIFO_DEPTH(64), .GAP_CLKS(48),
                  .DST_ADDR(DST), .SRC_ADDR(SRC), .ETH_TYPE(ETYP)) dut_long_i (
    .clk(clk), .rst_n(rst_n), .txen(txen_b), .txd(txd_b));

  frame_ref_model #(.L(40), .DEPTH(64), .GAP(48), .HDR(HDR)) ref_a (
    .clk(clk), .rst_n(rst_n), .txen(txen_a), .txd(txd_a),
    .n_chk(chk_a), .n_err(err_a), .n_frames(frm_a));

  frame_ref_model #(.L(50), .DEPTH(64), .GAP(48), .HDR(HDR)) ref_b (
    .clk(clk), .rst_n(rst_n), .txen(txen_b), .txd(txd_b),
    .n_chk(chk_b), .n_err(err_b), .n_frames(frm_b));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    checks += chk_a + chk_b;
    errors += err_a + err_b;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check(txen_a === 1'b0 && txd_a === 2'b00, "R1 reset outputs (short)", {txen_a, txd_a}, 0);
    check(txen_b === 1'b0 && txd_b === 2'b00, "R1 reset outputs (long)",  {txen_b, txd_b}, 0);
    #1 rst_n = 1'b1;
    repeat (1500) @(negedge clk);
    // R3: several frames must have started on both instances
    check(frm_a >= 3, "R3 frame count (short)", frm_a, 3);
    check(frm_b >= 3, "R3 frame count (long)",  frm_b, 3);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      finish_run();
    end
  end

endmodule